// File: doc/BRIEF.md
# Half-Bridge Input Interlock Controller

This block sits between a controller and the two gate drivers of one half-bridge leg. It takes a high-side command, a low-side command and a fault line that is shared by all phases and is active low. It produces one gate enable for each side. All three inputs are taken as synchronous to the block clock. Each input passes through its own digital pulse-width filter. A filtered input changes state only after the raw input has held its new level for a parameterised number of consecutive clocks. At a 100 MHz clock, a length of 10 to 50 cycles covers a window of 100 to 500 ns.

Each gate enable is set only by a rising edge of its own filtered command. It is cleared when that command falls. The block blocks both gates while both filtered commands are high, so the two switches never conduct together. It also blocks both gates while the filtered fault line is low. A block clears a gate's state, so when the block is lifted a command that is still high does not turn its gate back on. The gate stays off until the command goes low and then rises again. Both channels use the same registered path, so a gate turns on and turns off with the same delay.

Top module: `hb_interlock`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, both gate enables are low.
- R2: With no fault and only one filtered command high, the matching gate enable is high after that command's rising edge and the other gate enable is low.
- R3: A command input pulse shorter than CMD_FILT consecutive clocks leaves the gate enables as they were.
- R4: A low pulse on the fault line shorter than FLT_FILT consecutive clocks leaves the gate enables as they were.
- R5: When both filtered commands are high, both gate enables are low on the next cycle, and the two gate enables are never high together.
- R6: When the filtered fault line is low, both gate enables are low on the next cycle.
- R7: After the fault line returns high, a command that stayed high does not turn its gate on again. The gate turns on only after that command falls and rises again.
- R8: After an interlock ends, a command that stayed high does not turn its gate on again. The gate turns on only after that command falls and rises again.
- R9: A raw command change that is held reaches its gate enable exactly CMD_FILT+1 clocks later. This delay is the same for turn-on and turn-off and the same for both sides.
- R10: When a filtered command goes low, its gate enable goes low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd_i | input | 1 | High-side command, 1 = on |
| lo_cmd_i | input | 1 | Low-side command, 1 = on |
| fault_n_i | input | 1 | Shared fault line, 0 = fault |
| hi_gate_o | output | 1 | High-side gate enable |
| lo_gate_o | output | 1 | Low-side gate enable |

## Verification
The hardest case to reach is a command that is held high across the end of a block. The block can be an interlock or a fault, and it must last longer than the filter window on both sides of the change. Random toggling almost never holds an input steady that long. Directed sequences therefore hold one command high, then raise the other command or pull the fault line low for several filter windows. They then release the block and watch the gate stay off until the command falls and rises again. Random stimulus uses slow toggle rates, so that filtered changes, interlocks and faults occur often. A per-cycle model checks every cycle of this random run.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_HI   = 0;
    localparam int unsigned SIDE_LO   = 1;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } side_pair_t;

    function automatic logic rising(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

    function automatic logic shoot_through(input side_pair_t cmd);
        return cmd.hi & cmd.lo;
    endfunction
endpackage

// File: rtl/hbi_filter.sv
module hbi_filter #(
    parameter int unsigned LEN  = 16,
    parameter logic        INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_q <= INIT;
        end else if (raw_i == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            filt_q <= raw_i;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign filt_o = filt_q;

    // R3 / R4: the filtered value only ever moves to the level the raw input held
    p_filter_follow_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> (filt_q == $past(raw_i)));
endmodule

// File: rtl/hbi_channel.sv
module hbi_channel
    import hbi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_f_i,
    input  logic block_i,
    output logic gate_o
);
    gate_state_e state_q, state_d;
    logic        cmd_d_q;
    logic        edge_w;

    assign edge_w = rising(cmd_f_i, cmd_d_q);

    always_comb begin
        state_d = state_q;
        if (block_i)       state_d = GATE_OFF;
        else if (edge_w)   state_d = GATE_ON;
        else if (!cmd_f_i) state_d = GATE_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_OFF;
            cmd_d_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_d_q <= cmd_f_i;
        end
    end

    assign gate_o = (state_q == GATE_ON);

    // R7 / R8: a command level that was already high never turns an off gate on
    p_no_level_rearm_r8: assert property (@(posedge clk) disable iff (rst)
        (!gate_o && cmd_f_i && cmd_d_q) |=> !gate_o);

    // R10: a low filtered command leaves the gate off next cycle
    p_cmd_low_off_r10: assert property (@(posedge clk) disable iff (rst)
        !cmd_f_i |=> !gate_o);
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
    import hbi_pkg::*;
#(
    parameter int unsigned CMD_FILT = 16,
    parameter int unsigned FLT_FILT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_cmd_i,
    input  logic lo_cmd_i,
    input  logic fault_n_i,
    output logic hi_gate_o,
    output logic lo_gate_o
);
    side_pair_t raw_cmd, filt_cmd, gate;
    logic       fault_n_f;
    logic       block_w;

    assign raw_cmd.hi = hi_cmd_i;
    assign raw_cmd.lo = lo_cmd_i;

    hbi_filter #(.LEN(FLT_FILT), .INIT(1'b1)) u_fault_filt (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (fault_n_i),
        .filt_o (fault_n_f)
    );

    assign block_w = shoot_through(filt_cmd) | ~fault_n_f;

    genvar s;
    generate
        for (s = 0; s < NUM_SIDES; s++) begin : g_side
            hbi_filter #(.LEN(CMD_FILT), .INIT(1'b0)) u_filt (
                .clk    (clk),
                .rst    (rst),
                .raw_i  (raw_cmd[s]),
                .filt_o (filt_cmd[s])
            );
            hbi_channel u_chan (
                .clk     (clk),
                .rst     (rst),
                .cmd_f_i (filt_cmd[s]),
                .block_i (block_w),
                .gate_o  (gate[s])
            );
        end
    endgenerate

    assign hi_gate_o = gate.hi;
    assign lo_gate_o = gate.lo;

    // R5: overlapping filtered commands blank both gates
    p_interlock_r5: assert property (@(posedge clk) disable iff (rst)
        (filt_cmd.hi && filt_cmd.lo) |=> (!hi_gate_o && !lo_gate_o));

    // R5: the two gates never conduct together
    p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(hi_gate_o && lo_gate_o));

    // R6: a filtered fault blanks both gates
    p_fault_off_r6: assert property (@(posedge clk) disable iff (rst)
        !fault_n_f |=> (!hi_gate_o && !lo_gate_o));
endmodule

// File: tb/hb_interlock_test.sv
`timescale 1ns/1ps
module hb_interlock_test;
    localparam int unsigned CF = 16;
    localparam int unsigned FF = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hi_cmd = 1'b0, lo_cmd = 1'b0, fault_n = 1'b1;
    logic hi_gate, lo_gate;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // model state: filters (0 = hi, 1 = lo, 2 = fault)
    logic m_f [3];
    int   m_c [3];
    logic m_hd, m_ld, m_ho, m_lo;

    always #5 clk = ~clk;

    hb_interlock #(.CMD_FILT(CF), .FLT_FILT(FF)) uut (
        .clk(clk), .rst(rst), .hi_cmd_i(hi_cmd), .lo_cmd_i(lo_cmd),
        .fault_n_i(fault_n), .hi_gate_o(hi_gate), .lo_gate_o(lo_gate)
    );

    function automatic logic next_gate(logic cur, logic f, logic fd, logic blk);
        if (blk) return 1'b0;
        if (f && !fd) return 1'b1;
        if (!f) return 1'b0;
        return cur;
    endfunction

    task automatic model_reset();
        m_f[0] = 0; m_f[1] = 0; m_f[2] = 1;
        for (int i = 0; i < 3; i++) m_c[i] = 0;
        m_hd = 0; m_ld = 0; m_ho = 0; m_lo = 0;
    endtask

    task automatic model_filter(int i, logic raw, int len);
        if (raw == m_f[i]) m_c[i] = 0;
        else if (m_c[i] == len - 1) begin m_f[i] = raw; m_c[i] = 0; end
        else m_c[i] = m_c[i] + 1;
    endtask

    task automatic model_clock();
        logic blk;
        blk  = (m_f[0] && m_f[1]) || !m_f[2];
        m_ho = next_gate(m_ho, m_f[0], m_hd, blk);
        m_lo = next_gate(m_lo, m_f[1], m_ld, blk);
        m_hd = m_f[0];
        m_ld = m_f[1];
        model_filter(0, hi_cmd, CF);
        model_filter(1, lo_cmd, CF);
        model_filter(2, fault_n, FF);
    endtask

    task automatic check(string tag, string what, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        if (rst) model_reset(); else model_clock();
        @(negedge clk);
        check(tag, "hi_gate", hi_gate, m_ho);
        check(tag, "lo_gate", lo_gate, m_lo);
    endtask

    task automatic steps(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        model_reset();
        @(negedge clk);
        steps(3, "R1");
        rst = 1'b0;
        step("R1");
        check("R1", "hi after reset", hi_gate, 1'b0);
        check("R1", "lo after reset", lo_gate, 1'b0);

        // R9 turn-on latency on high side
        hi_cmd = 1;
        steps(CF, "R9");
        check("R9", "hi before CF+1", hi_gate, 1'b0);
        step("R9");
        check("R9", "hi at CF+1", hi_gate, 1'b1);
        steps(5, "R2");
        check("R2", "lo while hi only", lo_gate, 1'b0);
        // R10 / R9 turn-off latency
        hi_cmd = 0;
        steps(CF, "R10");
        check("R9", "hi still on before CF+1", hi_gate, 1'b1);
        step("R10");
        check("R10", "hi off at CF+1", hi_gate, 1'b0);

        // R9 / R2 low side
        lo_cmd = 1;
        steps(CF, "R9");
        check("R9", "lo before CF+1", lo_gate, 1'b0);
        step("R9");
        check("R2", "lo on", lo_gate, 1'b1);
        check("R2", "hi while lo only", hi_gate, 1'b0);
        lo_cmd = 0;
        steps(CF + 2, "R10");

        // R3 short pulse rejected
        hi_cmd = 1;
        steps(CF - 1, "R3");
        hi_cmd = 0;
        steps(2 * CF, "R3");
        check("R3", "short hi pulse", hi_gate, 1'b0);

        // R5 interlock then R8 no level re-arm
        hi_cmd = 1;
        steps(CF + 3, "R2");
        check("R2", "hi on before overlap", hi_gate, 1'b1);
        lo_cmd = 1;
        steps(CF + 2, "R5");
        check("R5", "hi off in overlap", hi_gate, 1'b0);
        check("R5", "lo off in overlap", lo_gate, 1'b0);
        lo_cmd = 0;
        steps(3 * CF, "R8");
        check("R8", "hi stays off after overlap", hi_gate, 1'b0);
        hi_cmd = 0;
        steps(CF + 2, "R8");
        hi_cmd = 1;
        steps(CF + 2, "R8");
        check("R8", "hi on after new edge", hi_gate, 1'b1);

        // R4 short fault pulse rejected
        fault_n = 0;
        steps(FF - 1, "R4");
        fault_n = 1;
        steps(2 * FF, "R4");
        check("R4", "hi survives short fault", hi_gate, 1'b1);

        // R6 fault, R7 no level re-arm
        fault_n = 0;
        steps(FF + 2, "R6");
        check("R6", "hi off in fault", hi_gate, 1'b0);
        fault_n = 1;
        steps(3 * FF, "R7");
        check("R7", "hi stays off after fault", hi_gate, 1'b0);
        hi_cmd = 0;
        steps(CF + 2, "R7");
        hi_cmd = 1;
        steps(CF + 2, "R7");
        check("R7", "hi on after new edge", hi_gate, 1'b1);
        hi_cmd = 0;
        steps(CF + 2, "R10");

        // random phase
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 20) == 0) hi_cmd = ~hi_cmd;
            if ($urandom_range(0, 24) == 0) lo_cmd = ~lo_cmd;
            if ($urandom_range(0, 60) == 0) fault_n = ~fault_n;
            step("R2");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule